// File: doc/BRIEF.md
# Looping Context Tile for a Coarse-Grained Array

This block is one tile of a word-level reconfigurable array. It holds an arithmetic unit, a four-entry local register file, a source multiplexer on each of its three operand inputs, and a small context store. Each context word sets the tile's whole behaviour for one clock cycle: the operation, where each operand comes from, which registers are read and written, and which result outputs are refreshed.

While the tile runs, it steps through contexts 0, 1, …, II-1 and then starts again at 0. II, the initiation interval, is captured when the tile starts. A loop body that was software-pipelined over II cycles therefore repeats with no loop-back branch.

Every context can be marked as predicated. When the predicate input is low, a predicated context has no architectural effect. This lets the first and last iterations of a pipelined loop be masked, so no separate prologue or epilogue code is needed. The arithmetic unit can also forward either source unchanged, so the tile can serve as a routing hop. Values written into the register file can be read back in later cycles, which lets the tile hold a value across time steps.

Top module: `cgra_tile`

## Requirements
- R1: After reset, `running`, `ctx_idx`, `cfg_err`, `pred_out` and all three result outputs are zero.
- R2: A `run_start` pulse while stopped sets `running` at the next edge with `ctx_idx` at 0. Each running cycle executes the context addressed by `ctx_idx`, which then advances by one and wraps from II-1 to 0.
- R3: II is captured from `ii_val` at start. A value of 0 behaves as 1, and a value above the context depth (8) behaves as the depth.
- R4: A `cfg_we` write while stopped stores `cfg_data` at `cfg_addr`. A write while running is ignored and sets `cfg_err`, which stays set until the next start. Context word fields are, by bit position: [3:0] opcode, [6:4] operand-0 source, [9:7] operand-1 source, [12:10] operand-2 source, [14:13] read address A, [16:15] read address B, [18:17] write address, [19] write enable, [20] write-data source (1 = operand 2, 0 = result), [23:21] output enables, [24] predicated.
- R5: Operand source codes are: 0 to 3 select the north, east, south and west neighbour words (`nbr_in` slice k occupies bits k*16 and up), 4 selects the row bus, 5 the column bus, 6 register read port A, and 7 register read port B.
- R6: Opcodes on 16-bit words, with A = operand 0 and B = operand 1: 0 A+B, 1 A-B, 2 AND, 3 OR, 4 XOR, 5 A shifted left by B[3:0], 6 A shifted right (logical) by B[3:0], 7 unsigned A<B as 0 or 1, 8 pass A, 9 pass B. Results wrap modulo 2^16.
- R7: An executed compare (opcode 7) loads `pred_out` with its outcome.
- R8: On an executed context, result output k (bits k*16 and up of `res_out`) loads the result when output-enable bit k is set. Outputs whose bit is clear hold their value.
- R9: A predicated context executed while `pred_in` is low changes no output, no register and not `pred_out`.
- R10: The register file is written at the end of an executed cycle. A read of the same entry in that cycle returns the old value, and written values persist for later contexts.
- R11: `run_stop` clears `running` at the next edge and returns `ctx_idx` to 0. While stopped, all outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Context write strobe |
| cfg_addr | input | 3 | Context entry to write |
| cfg_data | input | 25 | Context word |
| run_start | input | 1 | Begin looping from context 0 |
| run_stop | input | 1 | Halt looping |
| ii_val | input | 4 | Initiation interval, captured at start |
| pred_in | input | 1 | Predicate for predicated contexts |
| nbr_in | input | 64 | Four neighbour words: N, E, S, W |
| row_bus | input | 16 | Shared row bus word |
| col_bus | input | 16 | Shared column bus word |
| res_out | output | 48 | Three registered result words to neighbours |
| pred_out | output | 1 | Last executed compare outcome |
| running | output | 1 | Tile is looping |
| ctx_idx | output | 3 | Context executed in the current cycle |
| cfg_err | output | 1 | A write was attempted while running |

## Verification
The bench builds the tile with its default 16-bit words and eight context entries. With those values the interval clamp can be observed at the top of its range: a requested II of 12 must wrap after index 7. The four register entries are few enough that each test can use its own entry, with every entry still at its reset zero when first read. The three outputs allow a single run to show one output being refreshed while another holds.

// File: rtl/cgra_tile_pkg.sv
package cgra_tile_pkg;

    localparam int OP_W  = 4;
    localparam int SEL_W = 3;
    localparam int N_SRC = 3;
    localparam int N_OUT = 3;
    localparam int RF_AW = 2;
    localparam int N_NBR = 4;

    localparam logic [SEL_W-1:0] SRC_ROW = 3'd4;
    localparam logic [SEL_W-1:0] SRC_COL = 3'd5;
    localparam logic [SEL_W-1:0] SRC_RFA = 3'd6;
    localparam logic [SEL_W-1:0] SRC_RFB = 3'd7;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 4'd0,
        OP_SUB   = 4'd1,
        OP_AND   = 4'd2,
        OP_OR    = 4'd3,
        OP_XOR   = 4'd4,
        OP_SHL   = 4'd5,
        OP_SHR   = 4'd6,
        OP_CLT   = 4'd7,
        OP_PASSA = 4'd8,
        OP_PASSB = 4'd9
    } op_e;

    typedef struct packed {
        logic             pred_en;
        logic [N_OUT-1:0] out_en;
        logic             wr_src;
        logic             wr_en;
        logic [RF_AW-1:0] wr_addr;
        logic [RF_AW-1:0] rd_b;
        logic [RF_AW-1:0] rd_a;
        logic [SEL_W-1:0] sel2;
        logic [SEL_W-1:0] sel1;
        logic [SEL_W-1:0] sel0;
        op_e              op;
    } ctx_t;

    localparam int CTX_W = $bits(ctx_t);

endpackage

// File: rtl/tile_ctx_seq.sv
module tile_ctx_seq
    import cgra_tile_pkg::*;
#(
    parameter  int CTX_DEPTH = 8,
    localparam int AW        = $clog2(CTX_DEPTH),
    localparam int IIW       = $clog2(CTX_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [CTX_W-1:0] cfg_data,
    input  logic             run_start,
    input  logic             run_stop,
    input  logic [IIW-1:0]   ii_val,
    output logic             running,
    output logic [AW-1:0]    ctx_idx,
    output logic [IIW-1:0]   ii_eff,
    output logic             cfg_err,
    output ctx_t             cur_ctx
);

    typedef struct packed {
        logic           running;
        logic [AW-1:0]  idx;
        logic [IIW-1:0] ii;
        logic           err;
    } seq_t;

    seq_t s_d, s_q;
    logic [CTX_W-1:0] mem_q [CTX_DEPTH];

    function automatic logic [IIW-1:0] clamp_ii(input logic [IIW-1:0] v);
        if (v == '0)
            return IIW'(1);
        else if (v > IIW'(CTX_DEPTH))
            return IIW'(CTX_DEPTH);
        else
            return v;
    endfunction

    always_comb begin
        logic [IIW:0] nxt;
        s_d = s_q;
        nxt = (IIW+1)'(s_q.idx) + 1'b1;
        if (run_stop) begin
            s_d.running = 1'b0;
            s_d.idx     = '0;
        end else if (run_start && !s_q.running) begin
            s_d.running = 1'b1;
            s_d.idx     = '0;
            s_d.ii      = clamp_ii(ii_val);
            s_d.err     = 1'b0;
        end else if (s_q.running) begin
            if (nxt >= (IIW+1)'(s_q.ii))
                s_d.idx = '0;
            else
                s_d.idx = AW'(nxt);
        end
        if (cfg_we && s_q.running)
            s_d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{running: 1'b0, idx: '0, ii: IIW'(1), err: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < CTX_DEPTH; i++) mem_q[i] <= '0;
        end else if (cfg_we && !s_q.running) begin
            mem_q[cfg_addr] <= cfg_data;
        end
    end

    assign running = s_q.running;
    assign ctx_idx = s_q.idx;
    assign ii_eff  = s_q.ii;
    assign cfg_err = s_q.err;
    assign cur_ctx = ctx_t'(mem_q[s_q.idx]);

endmodule

// File: rtl/tile_rf.sv
module tile_rf
    import cgra_tile_pkg::*;
#(
    parameter  int DATA_W = 16,
    localparam int DEPTH  = 1 << RF_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [RF_AW-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [RF_AW-1:0]  raddr_a,
    input  logic [RF_AW-1:0]  raddr_b,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b
);

    logic [DEPTH-1:0][DATA_W-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we)
            regs_d[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            regs_q <= '0;
        else
            regs_q <= regs_d;
    end

    assign rdata_a = regs_q[raddr_a];
    assign rdata_b = regs_q[raddr_b];

endmodule

// File: rtl/tile_fu.sv
module tile_fu
    import cgra_tile_pkg::*;
#(
    parameter  int DATA_W = 16,
    localparam int SHW    = $clog2(DATA_W)
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] result,
    output logic              lt
);

    always_comb begin
        lt = (a < b);
        unique case (op)
            OP_ADD:   result = a + b;
            OP_SUB:   result = a - b;
            OP_AND:   result = a & b;
            OP_OR:    result = a | b;
            OP_XOR:   result = a ^ b;
            OP_SHL:   result = a << b[SHW-1:0];
            OP_SHR:   result = a >> b[SHW-1:0];
            OP_CLT:   result = DATA_W'(lt);
            OP_PASSA: result = a;
            OP_PASSB: result = b;
            default:  result = '0;
        endcase
    end

endmodule

// File: rtl/cgra_tile.sv
module cgra_tile
    import cgra_tile_pkg::*;
#(
    parameter  int DATA_W    = 16,
    parameter  int CTX_DEPTH = 8,
    localparam int AW        = $clog2(CTX_DEPTH),
    localparam int IIW       = $clog2(CTX_DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [AW-1:0]           cfg_addr,
    input  logic [CTX_W-1:0]        cfg_data,
    input  logic                    run_start,
    input  logic                    run_stop,
    input  logic [IIW-1:0]          ii_val,
    input  logic                    pred_in,
    input  logic [N_NBR*DATA_W-1:0] nbr_in,
    input  logic [DATA_W-1:0]       row_bus,
    input  logic [DATA_W-1:0]       col_bus,
    output logic [N_OUT*DATA_W-1:0] res_out,
    output logic                    pred_out,
    output logic                    running,
    output logic [AW-1:0]           ctx_idx,
    output logic                    cfg_err
);

    typedef struct packed {
        logic [N_OUT-1:0][DATA_W-1:0] res;
        logic                         pred;
    } out_t;

    ctx_t              cur_ctx;
    logic [IIW-1:0]    ii_eff;
    logic [DATA_W-1:0] rf_a, rf_b;
    logic [DATA_W-1:0] opnd  [N_SRC];
    logic [SEL_W-1:0]  sel_v [N_SRC];
    logic [DATA_W-1:0] fu_res;
    logic              fu_lt;
    logic              active;
    logic              rf_we;
    logic [DATA_W-1:0] rf_wdata;
    out_t              o_d, o_q;

    tile_ctx_seq #(.CTX_DEPTH(CTX_DEPTH)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_data  (cfg_data),
        .run_start (run_start),
        .run_stop  (run_stop),
        .ii_val    (ii_val),
        .running   (running),
        .ctx_idx   (ctx_idx),
        .ii_eff    (ii_eff),
        .cfg_err   (cfg_err),
        .cur_ctx   (cur_ctx)
    );

    assign sel_v[0] = cur_ctx.sel0;
    assign sel_v[1] = cur_ctx.sel1;
    assign sel_v[2] = cur_ctx.sel2;

    for (genvar g = 0; g < N_SRC; g++) begin : g_opnd
        always_comb begin
            if (sel_v[g] < SEL_W'(N_NBR)) begin
                opnd[g] = nbr_in[int'(sel_v[g])*DATA_W +: DATA_W];
            end else begin
                unique case (sel_v[g])
                    SRC_ROW: opnd[g] = row_bus;
                    SRC_COL: opnd[g] = col_bus;
                    SRC_RFA: opnd[g] = rf_a;
                    default: opnd[g] = rf_b;
                endcase
            end
        end
    end

    tile_fu #(.DATA_W(DATA_W)) u_fu (
        .op     (cur_ctx.op),
        .a      (opnd[0]),
        .b      (opnd[1]),
        .result (fu_res),
        .lt     (fu_lt)
    );

    assign active   = running && (!cur_ctx.pred_en || pred_in);
    assign rf_we    = active && cur_ctx.wr_en;
    assign rf_wdata = cur_ctx.wr_src ? opnd[2] : fu_res;

    tile_rf #(.DATA_W(DATA_W)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .waddr   (cur_ctx.wr_addr),
        .wdata   (rf_wdata),
        .raddr_a (cur_ctx.rd_a),
        .raddr_b (cur_ctx.rd_b),
        .rdata_a (rf_a),
        .rdata_b (rf_b)
    );

    always_comb begin
        o_d = o_q;
        if (active) begin
            for (int k = 0; k < N_OUT; k++) begin
                if (cur_ctx.out_en[k])
                    o_d.res[k] = fu_res;
            end
            if (cur_ctx.op == OP_CLT)
                o_d.pred = fu_lt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            o_q <= '0;
        else
            o_q <= o_d;
    end

    assign res_out  = o_q.res;
    assign pred_out = o_q.pred;

endmodule

// File: rtl/cgra_tile_chk.sv
module cgra_tile_chk #(
    parameter int DEPTH = 8,
    parameter int AW    = 3,
    parameter int IIW   = 4,
    parameter int OUT_W = 48
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_start,
    input logic             run_stop,
    input logic             cfg_we,
    input logic             pred_in,
    input logic             cur_pred_en,
    input logic             running,
    input logic             cfg_err,
    input logic             pred_out,
    input logic [AW-1:0]    ctx_idx,
    input logic [IIW-1:0]   ii_eff,
    input logic [OUT_W-1:0] res_out
);

    always_comb begin
        if (rst_n) begin
            p_ii_range_r3: assert (ii_eff >= IIW'(1) && ii_eff <= IIW'(DEPTH))
                else $error("interval out of range");
        end
    end

    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && run_start && !run_stop) |=> (running && ctx_idx == '0));

    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !run_stop && ((IIW+1)'(ctx_idx) + 1'b1 >= (IIW+1)'(ii_eff)))
        |=> (ctx_idx == '0));

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !run_stop && ((IIW+1)'(ctx_idx) + 1'b1 < (IIW+1)'(ii_eff)))
        |=> (ctx_idx == $past(ctx_idx) + 1'b1));

    p_busy_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cfg_we) |=> cfg_err);

    p_pred_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cur_pred_en && !pred_in) |=> ($stable(res_out) && $stable(pred_out)));

    p_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        run_stop |=> (!running && ctx_idx == '0));

    p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> ($stable(res_out) && $stable(pred_out)));

endmodule

bind cgra_tile cgra_tile_chk #(
    .DEPTH (CTX_DEPTH),
    .AW    (AW),
    .IIW   (IIW),
    .OUT_W (cgra_tile_pkg::N_OUT * DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_start   (run_start),
    .run_stop    (run_stop),
    .cfg_we      (cfg_we),
    .pred_in     (pred_in),
    .cur_pred_en (cur_ctx.pred_en),
    .running     (running),
    .cfg_err     (cfg_err),
    .pred_out    (pred_out),
    .ctx_idx     (ctx_idx),
    .ii_eff      (ii_eff),
    .res_out     (res_out)
);

// File: tb/cgra_tile_tb.sv
`timescale 1ns/1ps
module cgra_tile_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [2:0]  cfg_addr;
    logic [24:0] cfg_data;
    logic        run_start, run_stop;
    logic [3:0]  ii_val;
    logic        pred_in;
    logic [63:0] nbr_in;
    logic [15:0] row_bus, col_bus;
    logic [47:0] res_out;
    logic        pred_out, running, cfg_err;
    logic [2:0]  ctx_idx;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    cgra_tile u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .run_start(run_start), .run_stop(run_stop),
        .ii_val(ii_val), .pred_in(pred_in), .nbr_in(nbr_in),
        .row_bus(row_bus), .col_bus(col_bus), .res_out(res_out),
        .pred_out(pred_out), .running(running), .ctx_idx(ctx_idx),
        .cfg_err(cfg_err)
    );

    // {opcode, A, B, expected}
    localparam logic [51:0] VEC [0:11] = '{
        {4'd0, 16'h1234, 16'h0101, 16'h1335},
        {4'd0, 16'hFFFF, 16'h0002, 16'h0001},
        {4'd1, 16'h0005, 16'h0007, 16'hFFFE},
        {4'd2, 16'hF0F0, 16'h3C3C, 16'h3030},
        {4'd3, 16'hF000, 16'h000F, 16'hF00F},
        {4'd4, 16'hAAAA, 16'hFFFF, 16'h5555},
        {4'd5, 16'h0003, 16'h0004, 16'h0030},
        {4'd6, 16'h8000, 16'h000F, 16'h0001},
        {4'd7, 16'h0003, 16'h0004, 16'h0001},
        {4'd7, 16'h0004, 16'h0003, 16'h0000},
        {4'd8, 16'hBEEF, 16'h1111, 16'hBEEF},
        {4'd9, 16'hBEEF, 16'h1111, 16'h1111}
    };

    function automatic logic [24:0] mk(input logic [3:0] op, input logic [2:0] s0, s1, s2,
                                       input logic [1:0] ra, rb, wa, input logic we, ws,
                                       input logic [2:0] oe, input logic pe);
        return {pe, oe, ws, we, wa, rb, ra, s2, s1, s0, op};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr_ctx(input logic [2:0] a, input logic [24:0] w);
        cfg_we = 1'b1; cfg_addr = a; cfg_data = w;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic start_run(input logic [3:0] ii);
        ii_val = ii; run_start = 1'b1;
        step();
        run_start = 1'b0;
    endtask

    task automatic stop_run();
        run_stop = 1'b1;
        step();
        run_stop = 1'b0;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] prev;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_data = '0;
        run_start = 1'b0; run_stop = 1'b0; ii_val = 4'd1; pred_in = 1'b0;
        nbr_in = '0; row_bus = '0; col_bus = '0;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        check("R1 running", 32'(running), 32'd0);
        check("R1 ctx_idx", 32'(ctx_idx), 32'd0);
        check("R1 cfg_err", 32'(cfg_err), 32'd0);
        check("R1 pred_out", 32'(pred_out), 32'd0);
        check("R1 res_out", res_out[31:0], 32'd0);
        check("R1 res_out2", 32'(res_out[47:32]), 32'd0);

        // R6 / R7 opcode table, operands from row and column bus
        for (int i = 0; i < 12; i++) begin
            wr_ctx(3'd0, mk(VEC[i][51:48], 3'd4, 3'd5, 3'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 3'b001, 1'b0));
            row_bus = VEC[i][47:32];
            col_bus = VEC[i][31:16];
            start_run(4'd1);
            step();
            check($sformatf("R6 op%0d", VEC[i][51:48]), 32'(res_out[15:0]), 32'(VEC[i][15:0]));
            if (VEC[i][51:48] == 4'd7)
                check("R7 compare flag", 32'(pred_out), 32'(VEC[i][0]));
            stop_run();
        end

        // R2 ring of three contexts
        start_run(4'd3);
        check("R2 first index", 32'(ctx_idx), 32'd0);
        for (int i = 0; i < 5; i++) begin
            step();
            check("R2 index sequence", 32'(ctx_idx), 32'((i + 1) % 3));
        end
        stop_run();
        check("R11 stopped", 32'(running), 32'd0);
        check("R11 index cleared", 32'(ctx_idx), 32'd0);

        // R3 clamping of the interval
        start_run(4'd0);
        step(); step();
        check("R3 zero acts as one", 32'(ctx_idx), 32'd0);
        stop_run();
        start_run(4'd12);
        repeat (7) step();
        check("R3 reaches top index", 32'(ctx_idx), 32'd7);
        step();
        check("R3 wraps at depth", 32'(ctx_idx), 32'd0);
        stop_run();

        // R5 / R8 neighbour sources, only output 2 enabled
        nbr_in = {16'h0020, 16'h0100, 16'h0002, 16'h0001};
        wr_ctx(3'd0, mk(4'd0, 3'd2, 3'd3, 3'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 3'b100, 1'b0));
        prev = res_out[15:0];
        start_run(4'd1);
        step();
        check("R5 south plus west", 32'(res_out[47:32]), 32'h0120);
        check("R8 disabled output holds", 32'(res_out[15:0]), 32'(prev));
        stop_run();

        // R4 write while running is ignored and flagged
        row_bus = 16'd3; col_bus = 16'd4;
        wr_ctx(3'd0, mk(4'd0, 3'd4, 3'd5, 3'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 3'b001, 1'b0));
        start_run(4'd1);
        step();
        check("R4 stored context runs", 32'(res_out[15:0]), 32'd7);
        wr_ctx(3'd0, mk(4'd1, 3'd4, 3'd5, 3'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 3'b001, 1'b0));
        check("R4 error flag set", 32'(cfg_err), 32'd1);
        step();
        check("R4 busy write ignored", 32'(res_out[15:0]), 32'd7);
        stop_run();
        start_run(4'd1);
        check("R4 flag cleared at start", 32'(cfg_err), 32'd0);
        step();
        check("R4 context unchanged", 32'(res_out[15:0]), 32'd7);
        stop_run();

        // R11 outputs hold while stopped
        prev = res_out[15:0];
        row_bus = 16'h9999;
        repeat (3) step();
        check("R11 output holds", 32'(res_out[15:0]), 32'(prev));

        // R10 value carried across contexts through port B
        wr_ctx(3'd0, mk(4'd8, 3'd4, 3'd0, 3'd0, 2'd0, 2'd0, 2'd2, 1'b1, 1'b0, 3'b000, 1'b0));
        wr_ctx(3'd1, mk(4'd9, 3'd0, 3'd7, 3'd0, 2'd0, 2'd2, 2'd0, 1'b0, 1'b0, 3'b001, 1'b0));
        row_bus = 16'h4242;
        start_run(4'd2);
        step(); step();
        check("R10 delayed value", 32'(res_out[15:0]), 32'h4242);
        stop_run();

        // R10 read of the entry written in the same cycle returns the old value
        wr_ctx(3'd0, mk(4'd8, 3'd6, 3'd0, 3'd4, 2'd3, 2'd0, 2'd3, 1'b1, 1'b1, 3'b001, 1'b0));
        row_bus = 16'h1111;
        start_run(4'd1);
        step();
        check("R10 old value read", 32'(res_out[15:0]), 32'h0000);
        row_bus = 16'h2222;
        step();
        check("R10 first write visible", 32'(res_out[15:0]), 32'h1111);
        step();
        check("R10 second write visible", 32'(res_out[15:0]), 32'h2222);
        stop_run();

        // R9 predicated context masked while pred_in is low
        wr_ctx(3'd0, mk(4'd8, 3'd4, 3'd0, 3'd0, 2'd0, 2'd0, 2'd0, 1'b1, 1'b0, 3'b001, 1'b1));
        wr_ctx(3'd1, mk(4'd8, 3'd6, 3'd0, 3'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 3'b010, 1'b0));
        prev = res_out[15:0];
        pred_in = 1'b0;
        row_bus = 16'h7777;
        start_run(4'd2);
        step();
        check("R9 output untouched", 32'(res_out[15:0]), 32'(prev));
        step();
        check("R9 register untouched", 32'(res_out[31:16]), 32'h0000);
        pred_in = 1'b1;
        step();
        check("R9 enabled output", 32'(res_out[15:0]), 32'h7777);
        step();
        check("R9 enabled register", 32'(res_out[31:16]), 32'h7777);
        stop_run();
        pred_in = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule